// File: doc/BRIEF.md
# Grouped Priority Interrupt Controller

This block gathers interrupt sources into three fixed groups (critical, main and peripheral) and reports all three groups at once in a single encoded status word. Each group has its own field in that word: a valid flag and the number of the lowest-numbered source that is pending and not masked. The main and peripheral groups each have a mask register in which a set bit blocks a source. The critical group has no mask. The block drives one interrupt request line to the processor. That line is raised whenever any group field is valid. Software reads the status word and serves the highest group that is valid: critical first, then main, then peripheral.

Up to 16 DMA-task request lines are collected into a task pending register with its own task mask. Any pending task that is not masked raises peripheral source 0. Software clears pending task bits by writing ones to them. The register interface is a plain 32-bit bus with a word address, a write strobe and a read port that answers one cycle after the address is presented.

Some codes are reserved in the packed fields so that they can carry boosted peripheral interrupts. Per-source boosting is treated as disabled, so these codes never appear. Critical code 2 is therefore never produced. Main code 4 is never produced, and main input 4 is ignored.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After reset the main mask reads 0x00010FFF (address 0), the peripheral mask reads 0x7FFFFC00 (address 1), the task pending register reads 0 (address 2), the task mask reads 0x0000FFFF (address 3), and the status word and cpu_irq are 0.
- R2: The critical field sits in status bits 10 (valid) and 9:8 (number). crit_irq[0], crit_irq[1] and crit_irq[2] report codes 0, 1 and 3 respectively. The lowest code present wins. Code 2 is never reported.
- R3: The main field sits in bits 21 (valid) and 20:16 (number). Main source n (n = 0..16) is blocked when main-mask bit 16-n is 1. The lowest-numbered unblocked active source is reported.
- R4: Main input 4 is ignored, so main code 4 is never reported, whatever the mask.
- R5: The peripheral field sits in bits 29 (valid) and 28:24 (number). Peripheral source n (n = 1..31, on per_irq[n-1]) is blocked when peripheral-mask bit 31-n is 1. The lowest-numbered unblocked active source is reported.
- R6: Each field is computed independently of the others. A field with nothing pending has its valid flag at 0 and its number at 0. All other status bits are 0.
- R7: A task pending bit is set while its dma_req line is high. It is cleared by writing 1 to that bit at address 2. Writing 0 leaves the bit unchanged. A set in the same cycle as a clear wins.
- R8: Peripheral source 0 is active when any task bit is pending and its task-mask bit (address 3, bit = task number) is 0. Source 0 is itself blocked by peripheral-mask bit 31.
- R9: The status word updates one clock after its inputs are sampled. cpu_irq equals the OR of the three valid flags, one clock later still.
- R10: bus_rdata returns, one clock after bus_addr is presented, the register at that address. Address 4 returns the status word. Unused addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| crit_irq | input | 3 | Critical group source lines |
| main_irq | input | 17 | Main group source lines, bit n is source n |
| per_irq | input | 31 | Peripheral source lines, bit i is source i+1 |
| dma_req | input | 16 | DMA task request lines |
| status_o | output | 32 | Encoded status word |
| cpu_irq | output | 1 | Interrupt request to the processor |

## Verification
The bench walks a single active source through every position of each group with the masks open. It then sweeps pseudo-random source and mask patterns against an arithmetic model. A reversed mask bit order would report a masked source or miss an open one. A wrong scan direction would report the highest source instead of the lowest. Main input 4 is driven alone and together with higher sources, so a design that forgot the reserved code would report 4. The DMA tests set a task in the same cycle as a write-one clear of that task, and write zeros to pending bits. A design that let the clear win, or that cleared on zero, would lose a pending task. The test also opens and closes the task mask and peripheral-mask bit 31 to check the source-0 path. The latency check samples the status word and the request line on the exact cycles they must change, so an extra or missing register shows up.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 3;

  // status word layout
  localparam int unsigned CRIT_V   = 10;
  localparam int unsigned CRIT_LSB = 8;
  localparam int unsigned CRIT_W   = 2;
  localparam int unsigned MAIN_V   = 21;
  localparam int unsigned MAIN_LSB = 16;
  localparam int unsigned MAIN_W   = 5;
  localparam int unsigned PER_V    = 29;
  localparam int unsigned PER_LSB  = 24;
  localparam int unsigned PER_W    = 5;

  localparam int unsigned N_MAIN   = 17;
  localparam int unsigned N_PER    = 32;
  localparam int unsigned MAIN_RSV = 4;

  typedef enum logic [AW-1:0] {
    A_MMASK = 3'd0,
    A_PMASK = 3'd1,
    A_TPEND = 3'd2,
    A_TMASK = 3'd3,
    A_STAT  = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              v;
    logic [PER_W-1:0]  num;
  } field_t;

  function automatic logic [DW-1:0] pack_status(field_t c, field_t m, field_t p);
    logic [DW-1:0] w;
    w = '0;
    w[CRIT_V] = c.v;
    w[CRIT_LSB +: CRIT_W] = c.num[CRIT_W-1:0];
    w[MAIN_V] = m.v;
    w[MAIN_LSB +: MAIN_W] = m.num[MAIN_W-1:0];
    w[PER_V] = p.v;
    w[PER_LSB +: PER_W] = p.num;
    return w;
  endfunction
endpackage

// File: rtl/gic_lowest.sv
module gic_lowest #(
  parameter int unsigned W  = 8,
  localparam int unsigned OW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          hit,
  output logic [OW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = OW'(i);
      end
    end
  end
endmodule

// File: rtl/gic_task_agg.sv
module gic_task_agg #(
  parameter int unsigned N_TASK = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_TASK-1:0] req,
  input  logic              clr_we,
  input  logic              msk_we,
  input  logic [N_TASK-1:0] wdata,
  output logic [N_TASK-1:0] pend,
  output logic [N_TASK-1:0] tmask,
  output logic              any
);
  logic [N_TASK-1:0] clr_bits;

  assign clr_bits = clr_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= '0;
      tmask <= '1;
    end else begin
      pend <= (pend & ~clr_bits) | req;
      if (msk_we) tmask <= wdata;
    end
  end

  assign any = |(pend & ~tmask);
endmodule

// File: rtl/gic_group.sv
module gic_group #(
  parameter int unsigned        N       = 17,
  parameter logic [N-1:0]       RSV_MAP = '0,
  localparam int unsigned       OW      = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] src,
  input  logic [N-1:0] mask_rev,
  output logic         hit,
  output logic [OW-1:0] idx
);
  logic [N-1:0] open_src;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_src
      if (RSV_MAP[g]) begin : g_rsv
        assign open_src[g] = 1'b0;
      end else begin : g_use
        assign open_src[g] = src[g] & ~mask_rev[N-1-g];
      end
    end
  endgenerate

  gic_lowest #(.W(N)) u_pick (
    .req (open_src),
    .hit (hit),
    .idx (idx)
  );
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl #(
  parameter int unsigned N_TASK    = 16,
  parameter logic [31:0] MMASK_RST = 32'h0001_0FFF,
  parameter logic [31:0] PMASK_RST = 32'h7FFF_FC00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [2:0]  crit_irq,
  input  logic [16:0] main_irq,
  input  logic [30:0] per_irq,
  input  logic [N_TASK-1:0] dma_req,
  output logic [31:0] status_o,
  output logic        cpu_irq
);
  import gic_pkg::*;

  localparam int unsigned MW = $clog2(N_MAIN);
  localparam int unsigned PW = $clog2(N_PER);
  localparam logic [N_MAIN-1:0] MAIN_RSV_MAP = N_MAIN'(1) << MAIN_RSV;

  logic [N_MAIN-1:0] mmask;
  logic [N_PER-1:0]  pmask;
  logic [N_TASK-1:0] task_pend;
  logic [N_TASK-1:0] task_mask;
  logic              task_any;
  logic              wr_mm, wr_pm, wr_tp, wr_tm;

  assign wr_mm = bus_wr && (bus_addr == A_MMASK);
  assign wr_pm = bus_wr && (bus_addr == A_PMASK);
  assign wr_tp = bus_wr && (bus_addr == A_TPEND);
  assign wr_tm = bus_wr && (bus_addr == A_TMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      mmask <= MMASK_RST[N_MAIN-1:0];
      pmask <= PMASK_RST;
    end else begin
      if (wr_mm) mmask <= bus_wdata[N_MAIN-1:0];
      if (wr_pm) pmask <= bus_wdata;
    end
  end

  gic_task_agg #(.N_TASK(N_TASK)) u_tasks (
    .clk    (clk),
    .rst    (rst),
    .req    (dma_req),
    .clr_we (wr_tp),
    .msk_we (wr_tm),
    .wdata  (bus_wdata[N_TASK-1:0]),
    .pend   (task_pend),
    .tmask  (task_mask),
    .any    (task_any)
  );

  // critical: fixed code map 0,1,3 with code 2 reserved
  field_t crit_f;
  always_comb begin
    crit_f = '0;
    if (crit_irq[0])      begin crit_f.v = 1'b1; crit_f.num = 5'd0; end
    else if (crit_irq[1]) begin crit_f.v = 1'b1; crit_f.num = 5'd1; end
    else if (crit_irq[2]) begin crit_f.v = 1'b1; crit_f.num = 5'd3; end
  end

  logic          main_hit;
  logic [MW-1:0] main_idx;
  gic_group #(.N(N_MAIN), .RSV_MAP(MAIN_RSV_MAP)) u_main (
    .src      (main_irq),
    .mask_rev (mmask),
    .hit      (main_hit),
    .idx      (main_idx)
  );

  logic          per_hit;
  logic [PW-1:0] per_idx;
  gic_group #(.N(N_PER), .RSV_MAP('0)) u_per (
    .src      ({per_irq, task_any}),
    .mask_rev (pmask),
    .hit      (per_hit),
    .idx      (per_idx)
  );

  field_t main_f, per_f;
  always_comb begin
    main_f.v   = main_hit;
    main_f.num = main_hit ? PER_W'(main_idx) : '0;
    per_f.v    = per_hit;
    per_f.num  = per_hit ? PER_W'(per_idx) : '0;
  end

  logic [31:0] status_q;
  logic        irq_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= pack_status(crit_f, main_f, per_f);
      irq_q    <= status_q[CRIT_V] | status_q[MAIN_V] | status_q[PER_V];
    end
  end
  assign status_o = status_q;
  assign cpu_irq  = irq_q;

  logic [31:0] rd_mux;
  always_comb begin
    case (bus_addr)
      A_MMASK: rd_mux = 32'(mmask);
      A_PMASK: rd_mux = pmask;
      A_TPEND: rd_mux = 32'(task_pend);
      A_TMASK: rd_mux = 32'(task_mask);
      A_STAT:  rd_mux = status_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  logic unused_ok;
  assign unused_ok = ^{bus_wdata[31:N_MAIN], MMASK_RST[31:N_MAIN]};
endmodule

// File: rtl/grp_irq_chk.sv
module grp_irq_chk #(
  parameter int unsigned N_TASK = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       status,
  input logic              cpu_irq,
  input logic              bus_wr,
  input logic [2:0]        bus_addr,
  input logic [N_TASK-1:0] pend
);
  // R9
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    (status[10] | status[21] | status[29]) |=> cpu_irq);
  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(status[10] | status[21] | status[29]) |=> !cpu_irq);
  // R2
  crit_rsv_code_chk: assert property (@(posedge clk) disable iff (rst)
    status[10] |-> (status[9:8] != 2'd2));
  // R4
  main_rsv_code_chk: assert property (@(posedge clk) disable iff (rst)
    status[21] |-> (status[20:16] != 5'd4));
  // R6
  empty_fields_chk: assert property (@(posedge clk) disable iff (rst)
    ((status[10] || status[9:8] == 2'd0) &&
     (status[21] || status[20:16] == 5'd0) &&
     (status[29] || status[28:24] == 5'd0) &&
     status[7:0] == 8'd0 && status[15:11] == 5'd0 &&
     status[23:22] == 2'd0 && status[31:30] == 2'd0));
  // R7
  pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 3'd2) |=> ((pend & $past(pend)) == $past(pend)));
endmodule

bind grp_irq_ctrl grp_irq_chk #(.N_TASK(N_TASK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .status   (status_o),
  .cpu_irq  (cpu_irq),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .pend     (task_pend)
);

// File: tb/tb_grp_irq_ctrl.sv
module tb_grp_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  crit_irq = '0;
  logic [16:0] main_irq = '0;
  logic [30:0] per_irq = '0;
  logic [15:0] dma_req = '0;
  logic [31:0] status_o;
  logic        cpu_irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] lfsr = 32'hACE1_1234;

  // bench-side copies of the registers
  logic [31:0] m_mm, m_pm;
  logic [15:0] m_tp, m_tm;

  always #5 clk = ~clk;

  grp_irq_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .crit_irq(crit_irq),
    .main_irq(main_irq), .per_irq(per_irq), .dma_req(dma_req),
    .status_o(status_o), .cpu_irq(cpu_irq)
  );

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model();
    logic [31:0] w = '0;
    logic [31:0] psrc;
    if (crit_irq[0])      begin w[10] = 1; w[9:8] = 0; end
    else if (crit_irq[1]) begin w[10] = 1; w[9:8] = 1; end
    else if (crit_irq[2]) begin w[10] = 1; w[9:8] = 3; end
    for (int n = 16; n >= 0; n--)
      if (n != 4 && main_irq[n] && !m_mm[16-n]) begin w[21] = 1; w[20:16] = 5'(n); end
    psrc = {per_irq, |(m_tp & ~m_tm)};
    for (int n = 31; n >= 0; n--)
      if (psrc[n] && !m_pm[31-n]) begin w[29] = 1; w[28:24] = 5'(n); end
    return w;
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      3'd0: m_mm = {15'd0, d[16:0]};
      3'd1: m_pm = d;
      3'd2: m_tp = m_tp & ~d[15:0];
      3'd3: m_tm = d[15:0];
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  task automatic settle_chk(input string req);
    repeat (3) @(negedge clk);
    chk(req, status_o, model());
    chk({req, " R9 irq"}, {31'd0, cpu_irq}, {31'd0, |{model()[10], model()[21], model()[29]}});
  endtask

  initial begin
    m_mm = 32'h0001_0FFF; m_pm = 32'h7FFF_FC00; m_tp = 0; m_tm = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", status_o, 32'd0);
    chk("R1 irq", {31'd0, cpu_irq}, 32'd0);
    rd("R1 mmask", 3'd0, 32'h0001_0FFF);
    rd("R1 pmask", 3'd1, 32'h7FFF_FC00);
    rd("R1 tpend", 3'd2, 32'd0);
    rd("R1 tmask", 3'd3, 32'h0000_FFFF);
    rd("R10 unused addr", 3'd6, 32'd0);

    // R9 exact latency
    crit_irq = 3'b010;
    @(negedge clk);
    chk("R9 status one clock", status_o, 32'h0000_0500);
    chk("R9 irq not yet", {31'd0, cpu_irq}, 32'd0);
    @(negedge clk);
    chk("R9 irq one clock later", {31'd0, cpu_irq}, 32'd1);
    rd("R10 status readback", 3'd4, 32'h0000_0500);
    crit_irq = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 irq drops", {31'd0, cpu_irq}, 32'd0);

    // R2 all critical patterns
    for (int c = 0; c < 8; c++) begin
      crit_irq = 3'(c);
      settle_chk("R2 critical sweep");
    end
    crit_irq = 0;

    // R3 / R4 main walk with open mask
    wr(3'd0, 32'd0);
    rd("R10 mmask readback", 3'd0, 32'd0);
    for (int n = 0; n < 17; n++) begin
      main_irq = 17'(1) << n;
      settle_chk(n == 4 ? "R4 main input 4 alone" : "R3 main walk");
    end
    main_irq = 17'h0_0030;
    settle_chk("R4 main 4 with 5 behind it");

    // R5 peripheral walk, sources 1..31
    wr(3'd1, 32'd0);
    for (int n = 1; n < 32; n++) begin
      per_irq = 31'(1) << (n - 1);
      settle_chk("R5 peripheral walk");
    end
    per_irq = 0;

    // R3 R5 R6 random sources and masks
    for (int k = 0; k < 120; k++) begin
      lfsr = nxt(lfsr); main_irq = lfsr[16:0];
      lfsr = nxt(lfsr); per_irq = lfsr[30:0];
      lfsr = nxt(lfsr); crit_irq = (k % 3 == 0) ? lfsr[2:0] : 3'd0;
      lfsr = nxt(lfsr); wr(3'd0, lfsr | nxt(lfsr));
      lfsr = nxt(lfsr); wr(3'd1, lfsr | nxt(lfsr));
      settle_chk("R6 random mix");
    end
    crit_irq = 0; main_irq = 0; per_irq = 0;
    wr(3'd0, 32'h0001_FFFF);
    wr(3'd1, 32'h7FFF_FFFF);

    // R7 task pending set and write-one clear
    dma_req = 16'h8421;
    @(negedge clk);
    dma_req = 0; m_tp = 16'h8421;
    rd("R7 pend set", 3'd2, 32'h0000_8421);
    settle_chk("R8 masked tasks raise nothing");
    wr(3'd2, 32'h0000_0000);
    rd("R7 write zero keeps", 3'd2, 32'h0000_8421);
    wr(3'd2, 32'h0000_0401);
    rd("R7 w1c", 3'd2, 32'h0000_8020);
    // set and clear of bit 5 in the same cycle
    dma_req = 16'h0020;
    wr(3'd2, 32'h0000_0020);
    dma_req = 0; m_tp = 16'h8020;
    rd("R7 set wins over clear", 3'd2, 32'h0000_8020);

    // R8 task mask routing into peripheral source 0
    wr(3'd3, 32'h0000_7FFF);
    rd("R10 tmask readback", 3'd3, 32'h0000_7FFF);
    settle_chk("R8 unmasked task 15");
    chk("R8 source 0 reported", status_o, 32'h2000_0000);
    wr(3'd1, 32'hFFFF_FFFF);
    settle_chk("R8 source 0 blocked by pmask bit 31");
    chk("R8 blocked value", status_o, 32'd0);
    wr(3'd1, 32'h7FFF_FFFF);
    wr(3'd3, 32'h0000_FFDF);
    settle_chk("R8 task 5 open");
    wr(3'd2, 32'h0000_0020);
    settle_chk("R8 cleared task 5 drops source 0");
    chk("R8 dropped value", status_o, 32'd0);
    for (int t = 0; t < 16; t++) begin
      wr(3'd3, ~(32'd1 << t));
      dma_req = 16'(1) << t;
      @(negedge clk);
      dma_req = 0; m_tp = m_tp | (16'(1) << t);
      settle_chk("R8 per-task sweep");
      wr(3'd2, 32'd1 << t);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule